// File: doc/BRIEF.md
# Byte-Wide Asynchronous Serial Port

This block is an 8-bit asynchronous serial port that sits on a simple byte-wide register bus. It has two addresses. The control/status register holds the mode and option bits, the receiver enable, the ninth-bit fields, and two sticky completion flags. The data address writes the transmit shifter and reads the receive buffer, and these are two separate storage elements. Only the variable-rate 8-bit UART mode moves data. The bits that select the other modes are stored and read back, but they do not change the line behaviour.

Bit timing comes from a strobe that an external timer pulses on each overflow. One bit time is a fixed count of these strobes, 32 by default. Software writes a byte to the data address and a frame leaves on the transmit line. A falling edge on the receive line starts the assembly of an incoming frame, and the port samples each bit near its centre. The block raises a single interrupt request while either completion flag is set.

A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high. Software sets up the port by writing 0x50 to the control register. This selects the 8-bit variable-rate UART with the receiver on.

Top module: `serial_port8`

## Requirements
- R1: After reset, both register addresses read 0x00, the transmit line is high and the interrupt request is low.
- R2: The control register at 0x98 stores and reads back all eight bits in this order, MSB to LSB: mode1, mode0, mp_en, rx_en (bit 4), tx_bit9, rx_bit9 (bit 2), tx_flag (bit 1), rx_flag (bit 0).
- R3: A write to the data address 0x99 while idle drives the start bit low from the next cycle. The data bits follow LSB first, then a high stop bit, and the line returns to high afterwards.
- R4: Each transmitted bit lasts exactly DIV (32) pulses of the baud strobe.
- R5: tx_flag sets on the clock edge that ends the stop bit. The interrupt request equals tx_flag OR rx_flag.
- R6: Hardware never clears either flag. A software write to the control register sets or clears them, and a hardware set in the same cycle takes priority.
- R7: A write to the data address while a frame is being sent is ignored. The frame in progress is unchanged and no second frame follows.
- R8: A received frame (falling start edge, bits sampled at mid-bit, LSB first) loads the receive buffer read at 0x99. It copies the sampled stop bit into rx_bit9 and sets rx_flag.
- R9: A frame is committed only when rx_en is 1 and rx_flag is 0. Otherwise the receive buffer, rx_bit9 and rx_flag keep their values.
- R10: A start bit that reads high at its mid-point is discarded with no effect, and the receiver then accepts the next real frame.
- R11: Any other address reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse on each external timer overflow |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| irq | output | 1 | Interrupt request, high while either flag is set |

## Verification
Two situations are the hardest to reach from the ports. The first is a complete frame arriving while rx_flag is still set. The second is a start glitch that lasts less than half a bit. The bench creates the first by deliberately leaving the flag uncleared after a good frame and then sending a frame with a different byte. It creates the second by holding the receive line low for about five strobe pulses and then checking that nothing was committed. A behavioural model that counts strobes since the data write predicts the transmit line and tx_flag on every clock. Because of this, a write issued mid-frame shows up at once if the design lets it disturb the frame.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
   localparam int unsigned CTRL_W = 8;
   // control/status bit positions (software-visible, order is behaviour)
   localparam int unsigned B_RX_FLAG = 0;
   localparam int unsigned B_TX_FLAG = 1;
   localparam int unsigned B_RX_BIT9 = 2;
   localparam int unsigned B_TX_BIT9 = 3;
   localparam int unsigned B_RX_EN   = 4;
endpackage

// File: rtl/sp_sync.sv
`timescale 1ns/1ps
module sp_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial assert (STAGES >= 1) else $error("sp_sync: STAGES must be at least 1");

   generate
      if (STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= RESET_VAL;
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sp_tx.sv
`timescale 1ns/1ps
module sp_tx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              txd,
   output logic              busy,
   output logic              done
);
   localparam int unsigned FRAME_W = DATA_W + 2;
   localparam int unsigned CNT_W   = $clog2(DIV);
   localparam int unsigned IDX_W   = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] frame_q;
   logic [CNT_W-1:0]   tick_q;
   logic [IDX_W-1:0]   idx_q;
   logic               busy_q;
   logic               bit_end;

   assign bit_end = busy_q & baud_tick & (tick_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '1;
         tick_q  <= '0;
         idx_q   <= '0;
         busy_q  <= 1'b0;
      end else if (load && !busy_q) begin
         frame_q <= {1'b1, load_data, 1'b0};
         tick_q  <= '0;
         idx_q   <= '0;
         busy_q  <= 1'b1;
      end else if (busy_q && baud_tick) begin
         if (tick_q == CNT_LAST) begin
            tick_q <= '0;
            if (idx_q == IDX_LAST) busy_q <= 1'b0;
            else                   idx_q  <= idx_q + 1'b1;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   assign txd  = busy_q ? frame_q[idx_q] : 1'b1;
   assign busy = busy_q;
   assign done = bit_end & (idx_q == IDX_LAST);

   // R7: the frame being sent is never replaced
   a_r7_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(frame_q));
   // R4: the bit position moves only on a baud strobe
   a_r4_index_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !baud_tick) |=> $stable(idx_q));
   // R3: a frame begins with the start bit
   a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !busy_q) |=> !txd);
endmodule

// File: rtl/sp_rx.sv
`timescale 1ns/1ps
module sp_rx import sp_pkg::*; #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rxd,
   input  logic              arm,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              stop_bit
);
   localparam int unsigned CNT_W  = $clog2(DIV);
   localparam int unsigned BCNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(DIV - 1);
   localparam logic [CNT_W-1:0]  HALF_LAST = CNT_W'(DIV / 2 - 1);
   localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(DATA_W - 1);

   rx_state_e         state_q;
   logic [CNT_W-1:0]  tick_q;
   logic [BCNT_W-1:0] bcnt_q;
   logic [DATA_W-1:0] shift_q;
   logic              rxd_d;
   logic              stop_q;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         tick_q  <= '0;
         bcnt_q  <= '0;
         shift_q <= '0;
         rxd_d   <= 1'b1;
         stop_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         rxd_d  <= rxd;
         done_q <= 1'b0;
         case (state_q)
            RX_IDLE: begin
               if (arm && rxd_d && !rxd) begin
                  state_q <= RX_START;
                  tick_q  <= '0;
               end
            end
            RX_START: begin
               if (baud_tick) begin
                  if (tick_q == HALF_LAST) begin
                     tick_q <= '0;
                     bcnt_q <= '0;
                     state_q <= rxd ? RX_IDLE : RX_DATA;
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (baud_tick) begin
                  if (tick_q == CNT_LAST) begin
                     tick_q  <= '0;
                     shift_q <= {rxd, shift_q[DATA_W-1:1]};
                     if (bcnt_q == BCNT_LAST) state_q <= RX_STOP;
                     else                     bcnt_q  <= bcnt_q + 1'b1;
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (baud_tick) begin
                  if (tick_q == CNT_LAST) begin
                     tick_q  <= '0;
                     stop_q  <= rxd;
                     done_q  <= 1'b1;
                     state_q <= RX_IDLE;
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   assign done     = done_q;
   assign data     = shift_q;
   assign stop_bit = stop_q;

   // R10: data phase is entered only after a start bit that read low
   a_r10_start_confirmed_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_START && baud_tick && tick_q == HALF_LAST && rxd) |=> (state_q == RX_IDLE));
   // R8: completion pulse follows the stop-bit phase
   a_r8_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == RX_IDLE));
   // R8: received data is frozen outside the data phase
   a_r8_shift_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != RX_DATA) |=> $stable(shift_q));
endmodule

// File: rtl/sp_regs.sv
`timescale 1ns/1ps
module sp_regs import sp_pkg::*; #(
   parameter int unsigned         ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]   CTRL_ADDR = 8'h98,
   parameter logic [ADDR_W-1:0]   DATA_ADDR = 8'h99
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CTRL_W-1:0] bus_wdata,
   output logic [CTRL_W-1:0] bus_rdata,
   input  logic              tx_done,
   input  logic              rx_done,
   input  logic [CTRL_W-1:0] rx_data,
   input  logic              rx_stop,
   output logic              rx_arm,
   output logic              tx_load,
   output logic [CTRL_W-1:0] tx_data,
   output logic              irq
);
   logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;
   logic [CTRL_W-1:0] rbuf_q;
   logic sel_ctrl, sel_data, wr_ctrl, accept;

   assign sel_ctrl = (bus_addr == CTRL_ADDR);
   assign sel_data = (bus_addr == DATA_ADDR);
   assign wr_ctrl  = bus_wr & sel_ctrl;
   assign accept   = rx_done & ctrl_q[B_RX_EN] & ~ctrl_q[B_RX_FLAG];

   always_comb begin
      ctrl_nxt = wr_ctrl ? bus_wdata : ctrl_q;
      if (tx_done) ctrl_nxt[B_TX_FLAG] = 1'b1;
      if (accept) begin
         ctrl_nxt[B_RX_FLAG] = 1'b1;
         ctrl_nxt[B_RX_BIT9] = rx_stop;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         rbuf_q <= '0;
      end else begin
         ctrl_q <= ctrl_nxt;
         if (accept) rbuf_q <= rx_data;
      end
   end

   always_comb begin
      if (sel_ctrl)      bus_rdata = ctrl_q;
      else if (sel_data) bus_rdata = rbuf_q;
      else               bus_rdata = '0;
   end

   assign rx_arm  = ctrl_q[B_RX_EN];
   assign tx_load = bus_wr & sel_data;
   assign tx_data = bus_wdata;
   assign irq     = ctrl_q[B_TX_FLAG] | ctrl_q[B_RX_FLAG];

   // R5: end of a transmitted frame raises tx_flag
   a_r5_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> ctrl_q[B_TX_FLAG]);
   // R6: flags only fall through a software write
   a_r6_tx_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[B_TX_FLAG] && !wr_ctrl) |=> ctrl_q[B_TX_FLAG]);
   a_r6_rx_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[B_RX_FLAG] && !wr_ctrl) |=> ctrl_q[B_RX_FLAG]);
   // R9: buffer held while pending or disabled
   a_r9_rbuf_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[B_RX_FLAG] || !ctrl_q[B_RX_EN]) |=> $stable(rbuf_q));
   // R11: control changes only by a write here or by a completion
   a_r11_ctrl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ctrl && !tx_done && !rx_done) |=> $stable(ctrl_q));
endmodule

// File: rtl/serial_port8.sv
`timescale 1ns/1ps
module serial_port8 import sp_pkg::*; #(
   parameter int unsigned       ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h98,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h99,
   parameter int unsigned       DIV         = 32,
   parameter int unsigned       SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              txd,
   input  logic              rxd,
   output logic              irq
);
   localparam int unsigned DATA_W = CTRL_W;

   initial begin
      assert (DIV >= 4 && (DIV % 2) == 0) else $error("serial_port8: DIV must be even and >= 4");
      assert (CTRL_ADDR != DATA_ADDR) else $error("serial_port8: register addresses collide");
      assert (SYNC_STAGES >= 1) else $error("serial_port8: SYNC_STAGES must be >= 1");
   end

   logic              rxd_s;
   logic              tx_load, tx_busy, tx_done;
   logic [DATA_W-1:0] tx_data;
   logic              rx_done, rx_stop, rx_arm;
   logic [DATA_W-1:0] rx_data;

   sp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

   sp_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_done(tx_done),
      .rx_done(rx_done), .rx_data(rx_data), .rx_stop(rx_stop), .rx_arm(rx_arm),
      .tx_load(tx_load), .tx_data(tx_data), .irq(irq));

   sp_tx #(.DATA_W(DATA_W), .DIV(DIV)) u_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(tx_load),
      .load_data(tx_data), .txd(txd), .busy(tx_busy), .done(tx_done));

   sp_rx #(.DATA_W(DATA_W), .DIV(DIV)) u_rx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd_s), .arm(rx_arm),
      .done(rx_done), .data(rx_data), .stop_bit(rx_stop));

   // R7: busy does not drop while a write attempts to start a frame
   a_r7_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && tx_load && !tx_done) |=> tx_busy);
endmodule

// File: tb/serial_port8_test.sv
`timescale 1ns/1ps
module serial_port8_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [7:0] bus_addr = 8'h98;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       txd;
   logic       rxd = 1'b1;
   logic       irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   serial_port8 uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .txd(txd), .rxd(rxd), .irq(irq));

   initial forever #2 clk = ~clk;

   // baud strobe: one pulse every second clock
   initial forever begin
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural transmit model: strobes counted since the accepted write
   bit         m_busy = 1'b0;
   bit         m_was_busy;
   bit         m_ti = 1'b0;
   bit         m_done;
   int         m_ticks = 0;
   logic [7:0] m_data = 8'h00;
   logic       m_txd;
   int         m_bit;
   bit         exp_ri = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1'b0; m_ti = 1'b0; m_ticks = 0;
      end else begin
         m_was_busy = m_busy;
         m_done = 1'b0;
         if (m_busy && baud_tick) begin
            m_ticks++;
            if (m_ticks == 320) begin m_busy = 1'b0; m_done = 1'b1; end
         end
         if (bus_wr && bus_addr == 8'h98) m_ti = bus_wdata[1];
         if (m_done) m_ti = 1'b1;
         if (bus_wr && bus_addr == 8'h99 && !m_was_busy) begin
            m_busy = 1'b1; m_ticks = 0; m_data = bus_wdata;
         end
         #1;
         m_bit = m_ticks / 32;
         if (!m_busy)          m_txd = 1'b1;
         else if (m_bit == 0)  m_txd = 1'b0;
         else if (m_bit <= 8)  m_txd = m_data[m_bit-1];
         else                  m_txd = 1'b1;
         chk("R3 R4 R7 txd per clock", int'(txd), int'(m_txd));
         if (bus_addr == 8'h98) chk("R5 R6 tx_flag per clock", int'(bus_rdata[1]), int'(m_ti));
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h98;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk); bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk); bus_addr = 8'h98;
   endtask

   task automatic send_rx(input logic [7:0] b, input logic stop);
      @(negedge clk); rxd = 1'b0;
      repeat (64) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (64) @(negedge clk);
      end
      rxd = stop;
      repeat (64) @(negedge clk);
      rxd = 1'b1;
      repeat (20) @(negedge clk);
   endtask

   task automatic wait_tx();
      while (m_busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      repeat (5) @(negedge clk);
      rd(8'h98, v); chk("R1 ctrl after reset", v, 8'h00);
      rd(8'h99, v); chk("R1 data after reset", v, 8'h00);
      chk("R1 txd after reset", txd, 1);
      chk("R1 irq after reset", irq, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      wr(8'h98, 8'hEC); rd(8'h98, v); chk("R2 readback EC", v, 8'hEC);
      wr(8'h98, 8'h50); rd(8'h98, v); chk("R2 readback 50", v, 8'h50);

      // transmit with a mid-frame write
      wr(8'h99, 8'hA5);
      repeat (200) @(negedge clk);
      wr(8'h99, 8'h0F);
      wait_tx();
      rd(8'h98, v); chk("R5 tx_flag after frame", v, 8'h52);
      chk("R5 irq with tx_flag", irq, 1);
      repeat (300) @(negedge clk);
      chk("R6 tx_flag held", irq, 1);
      chk("R7 no second frame", txd, 1);
      wr(8'h98, 8'h50);
      chk("R6 software clear", irq, 0);

      // second pattern, and a software set
      wr(8'h99, 8'h3C);
      wait_tx();
      chk("R5 irq second frame", irq, 1);
      wr(8'h98, 8'h50);
      wr(8'h98, 8'h52);
      chk("R6 software set", irq, 1);
      wr(8'h98, 8'h50);

      // receive
      send_rx(8'h3C, 1'b1); exp_ri = 1'b1;
      rd(8'h99, v); chk("R8 rx byte", v, 8'h3C);
      rd(8'h98, v); chk("R8 rx status", v, 8'h55);
      chk("R5 irq with rx_flag", irq, int'(m_ti | exp_ri));

      send_rx(8'h99, 1'b0);
      rd(8'h99, v); chk("R9 held while flag set", v, 8'h3C);
      rd(8'h98, v); chk("R9 status while flag set", v, 8'h55);

      wr(8'h98, 8'h40); exp_ri = 1'b0;
      send_rx(8'h77, 1'b1);
      rd(8'h99, v); chk("R9 disabled receiver data", v, 8'h3C);
      rd(8'h98, v); chk("R9 disabled receiver status", v, 8'h40);
      chk("R9 irq disabled receiver", irq, 0);

      wr(8'h98, 8'h50);
      @(negedge clk); rxd = 1'b0;
      repeat (10) @(negedge clk); rxd = 1'b1;
      repeat (150) @(negedge clk);
      rd(8'h98, v); chk("R10 glitch ignored", v, 8'h50);
      send_rx(8'hC3, 1'b0);
      rd(8'h99, v); chk("R10 frame after glitch", v, 8'hC3);
      rd(8'h98, v); chk("R8 stop bit low stored", v, 8'h51);

      wr(8'h97, 8'hFF);
      rd(8'h97, v); chk("R11 other address reads zero", v, 8'h00);
      rd(8'h98, v); chk("R11 ctrl untouched", v, 8'h51);
      rd(8'h99, v); chk("R11 data untouched", v, 8'hC3);
      chk("R11 no frame started", txd, 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule